// File: doc/BRIEF.md
# Paced scatter-list DMA channel

One DMA channel moves a block of bytes between a device and memory. Memory is reached through a list of physical page addresses that the channel reads by index, starting at a byte offset inside the first page. The channel cuts the transfer into requests that never cross a cache-line boundary. Only one memory request is outstanding at any time. When it reaches the end of a page it moves on to the next page-list entry.

Requests are spread evenly over the time the caller allows. At start the channel derives a per-line interval from the deadline, the current value of a free-running cycle counter and the total length. A request is issued only when the counter has reached the channel's next-start time. A NAK response repeats the chunk in the next paced slot. An error response aborts the transfer. A finished transfer keeps the channel busy until the deadline and then pulses done.

Top module: `sg_dma_chan`

## Requirements
- R1: After reset, busy_o, done_o, err_o, start_reject_o, mem_req_valid_o and dev_valid_o are 0.
- R2: A start is rejected if it arrives while busy_o is 1 or if its length is 0. A rejected start raises start_reject_o for exactly the next cycle and has no other effect.
- R3: At an accepted start at counter value S, with deadline D, the interval is I = floor((D − S) × LINE / length). LINE is 256 when LINE_CFG is 0. The k-th request (k ≥ 1, retries counted) is never decided before counter value S + k·I. The first request is not held by pacing.
- R4: A deadline earlier than the counter value at start is replaced by that value: the interval is 0 and done follows the last chunk without waiting.
- R5: Each chunk is cut by the offset within its page. If the offset is not a multiple of LINE, the chunk runs up to the next multiple; otherwise it is LINE bytes. In both cases it is capped by the bytes remaining.
- R6: mem_req_addr_o is pg_addr_i (the entry at index pg_idx_o) plus the current offset. Index 0 is used first. When the offset reaches the page size it wraps to 0 and the index increases by 1.
- R7: With start_wr_i = 1 (device to memory), a device handshake (dev_valid_o with dev_ready_i) precedes each new chunk's memory request. With start_wr_i = 0 the device handshake follows an OK response.
- R8: Status 2'b01 (NAK) makes the channel repeat the same address and length in the next paced slot, with no extra device handshake; nothing is advanced.
- R9: A status with bit 1 set (error) ends the transfer: done_o pulses with err_o = 1 and busy_o falls. err_o stays 1 until the next accepted start clears it.
- R10: After the last chunk, done_o pulses for one cycle at the first counter value ≥ the deadline, and busy_o falls in that same cycle.
- R11: mem_req_valid_o is not raised while a request is waiting for its response, and it stays high with a stable address and length until mem_req_ready_i.
- R12: moved_o counts the bytes of chunks that completed with status 2'b00 (OK) since the last accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_i | input | TIME_W | Free-running cycle counter |
| start_valid_i | input | 1 | Start request |
| start_len_i | input | LEN_W | Transfer length in bytes |
| start_off_i | input | log2(PAGE_BYTES) | Byte offset within the first page |
| start_wr_i | input | 1 | 1: device to memory, 0: memory to device |
| start_deadline_i | input | TIME_W | Counter value by which the transfer should end |
| start_reject_o | output | 1 | One-cycle pulse for a rejected start |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky error status |
| moved_o | output | LEN_W | Bytes moved with OK status |
| pg_idx_o | output | IDX_W | Page-list index being read |
| pg_addr_i | input | ADDR_W | Page address at pg_idx_o |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_write_o | output | 1 | Request writes memory |
| mem_req_addr_o | output | ADDR_W | Request byte address |
| mem_req_len_o | output | log2(LINE)+1 | Request byte count |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_status_i | input | 2 | 00 OK, 01 NAK, 1x error |
| dev_valid_o | output | 1 | Device data handshake valid |
| dev_ready_i | input | 1 | Device data handshake ready |
| dev_to_mem_o | output | 1 | Device supplies data (1) or receives it (0) |
| dev_len_o | output | log2(LINE)+1 | Bytes in this device handshake |

## Verification
A fault in the offset or page-index state shows up in the first request after it. That request carries the wrong address or a length that crosses a line, so every request's address and length is compared against an independent chunk model. A wrong interval or next-start value shows up one interval later: the second request leaves at a counter value other than S + I plus the fixed pipeline latency. A fault in the completion hold shows as done_o arriving at a counter value other than deadline + 1. Retry and abort faults show at the ports within a cycle or two of the response, as an extra or missing device handshake, a changed moved_o, or a wrong err_o at done.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DIV, ST_PACE, ST_FETCH, ST_REQ, ST_RSP, ST_PUT, ST_HOLD
  } dma_st_e;

  localparam logic [1:0] RSP_OK  = 2'b00;
  localparam logic [1:0] RSP_NAK = 2'b01;

  function automatic logic rsp_is_err(input logic [1:0] s);
    return s[1];
  endfunction
endpackage

// File: rtl/sg_dma_div.sv
module sg_dma_div #(
  parameter int NUM_W = 40,
  parameter int DEN_W = 16,
  parameter int OUT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [OUT_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_q;
  logic [DEN_W-1:0] r_q, d_q, r_nx;
  logic [DEN_W:0]   r_sh;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, ge;

  always_comb begin
    r_sh = {r_q, q_q[NUM_W-1]};
    ge   = r_sh >= {1'b0, d_q};
    r_nx = ge ? DEN_W'(r_sh - {1'b0, d_q}) : DEN_W'(r_sh);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0; r_q <= '0; d_q <= '0; cnt_q <= '0; busy_q <= 1'b0;
    end else if (start_i) begin
      q_q <= num_i; r_q <= '0; d_q <= den_i;
      cnt_q <= CNT_W'(NUM_W); busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        r_q   <= r_nx;
        q_q   <= {q_q[NUM_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign done_o = busy_q && (cnt_q == '0);
  // saturate a quotient too wide for the time base
  assign quo_o  = (|q_q[NUM_W-1:OUT_W]) ? '1 : q_q[OUT_W-1:0];
endmodule

// File: rtl/sg_dma_pace.sv
module sg_dma_pace #(
  parameter int TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] cycle_i,
  input  logic              load_i,
  input  logic              ivl_we_i,
  input  logic [TIME_W-1:0] ivl_i,
  input  logic              step_i,
  output logic              due_o
);
  logic [TIME_W-1:0] next_q, ivl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= '0; ivl_q <= '0;
    end else begin
      if (load_i)        next_q <= cycle_i;
      else if (step_i)   next_q <= next_q + ivl_q;
      if (ivl_we_i)      ivl_q  <= ivl_i;
    end
  end

  assign due_o = cycle_i >= next_q;
endmodule

// File: rtl/sg_dma_chunk.sv
module sg_dma_chunk #(
  parameter int LINE_SH = 8,
  parameter int LEN_W   = 16,
  parameter int PG_W    = 12
) (
  input  logic [PG_W-1:0]    off_i,
  input  logic [LEN_W-1:0]   rem_i,
  output logic [LINE_SH:0]   len_o
);
  localparam int CL_W = LINE_SH + 1;
  logic [CL_W-1:0] room;

  always_comb begin
    // bytes left up to the next line boundary (full line when aligned)
    room  = CL_W'(1 << LINE_SH) - CL_W'(off_i[LINE_SH-1:0]);
    len_o = (rem_i < LEN_W'(room)) ? CL_W'(rem_i) : room;
  end
endmodule

// File: rtl/sg_dma_chan.sv
module sg_dma_chan
  import sg_dma_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int TIME_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 8,
  parameter int PAGE_BYTES = 4096,
  parameter int LINE_CFG   = 0,
  localparam int LINE_B    = (LINE_CFG == 0) ? 256 : LINE_CFG,
  localparam int LINE_SH   = $clog2(LINE_B),
  localparam int PG_W      = $clog2(PAGE_BYTES),
  localparam int CL_W      = LINE_SH + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] cycle_i,
  input  logic              start_valid_i,
  input  logic [LEN_W-1:0]  start_len_i,
  input  logic [PG_W-1:0]   start_off_i,
  input  logic              start_wr_i,
  input  logic [TIME_W-1:0] start_deadline_i,
  output logic              start_reject_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [LEN_W-1:0]  moved_o,
  output logic [IDX_W-1:0]  pg_idx_o,
  input  logic [ADDR_W-1:0] pg_addr_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_write_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [CL_W-1:0]   mem_req_len_o,
  input  logic              mem_rsp_valid_i,
  input  logic [1:0]        mem_rsp_status_i,
  output logic              dev_valid_o,
  input  logic              dev_ready_i,
  output logic              dev_to_mem_o,
  output logic [CL_W-1:0]   dev_len_o
);
  localparam int NUM_W = TIME_W + LINE_SH;

  dma_st_e           st_q;
  logic [LEN_W-1:0]  rem_q, moved_q;
  logic [PG_W-1:0]   off_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CL_W-1:0]   clen_q, clen_cut;
  logic [TIME_W-1:0] dl_q, dl_eff, ivl;
  logic              wr_q, retry_q, err_q, done_q, rej_q;
  logic              accept, div_done, due, step, adv;
  logic [PG_W:0]     off_sum;

  assign accept = (st_q == ST_IDLE) && start_valid_i && (start_len_i != '0);
  assign dl_eff = (start_deadline_i < cycle_i) ? cycle_i : start_deadline_i;
  assign step   = (st_q == ST_PACE) && (rem_q != '0) && due;

  // chunk completes: OK on a write, device hand-off on a read
  assign adv = ((st_q == ST_RSP) && mem_rsp_valid_i && (mem_rsp_status_i == RSP_OK) && wr_q) ||
               ((st_q == ST_PUT) && dev_ready_i);
  assign off_sum = {1'b0, off_q} + (PG_W+1)'(clen_q);

  sg_dma_div #(.NUM_W(NUM_W), .DEN_W(LEN_W), .OUT_W(TIME_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .num_i   ({dl_eff - cycle_i, {LINE_SH{1'b0}}}),
    .den_i   (start_len_i),
    .done_o  (div_done),
    .quo_o   (ivl)
  );

  sg_dma_pace #(.TIME_W(TIME_W)) u_pace (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cycle_i  (cycle_i),
    .load_i   (accept),
    .ivl_we_i (div_done && (st_q == ST_DIV)),
    .ivl_i    (ivl),
    .step_i   (step),
    .due_o    (due)
  );

  sg_dma_chunk #(.LINE_SH(LINE_SH), .LEN_W(LEN_W), .PG_W(PG_W)) u_chunk (
    .off_i (off_q),
    .rem_i (rem_q),
    .len_o (clen_cut)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      rem_q <= '0; moved_q <= '0; off_q <= '0; idx_q <= '0; clen_q <= '0;
      dl_q <= '0; wr_q <= 1'b0; retry_q <= 1'b0; err_q <= 1'b0;
      done_q <= 1'b0; rej_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rej_q  <= start_valid_i && ((st_q != ST_IDLE) || (start_len_i == '0));
      unique case (st_q)
        ST_IDLE: if (accept) begin
          wr_q <= start_wr_i; rem_q <= start_len_i; off_q <= start_off_i;
          idx_q <= '0; moved_q <= '0; err_q <= 1'b0; retry_q <= 1'b0;
          dl_q <= dl_eff; st_q <= ST_DIV;
        end
        ST_DIV: if (div_done) st_q <= ST_PACE;
        ST_PACE: begin
          if (rem_q == '0) st_q <= ST_HOLD;
          else if (due) begin
            clen_q <= clen_cut;
            st_q   <= (wr_q && !retry_q) ? ST_FETCH : ST_REQ;
          end
        end
        ST_FETCH: if (dev_ready_i) st_q <= ST_REQ;
        ST_REQ:   if (mem_req_ready_i) st_q <= ST_RSP;
        ST_RSP: if (mem_rsp_valid_i) begin
          if (rsp_is_err(mem_rsp_status_i)) begin
            err_q <= 1'b1; done_q <= 1'b1; st_q <= ST_IDLE;
          end else if (mem_rsp_status_i == RSP_NAK) begin
            retry_q <= 1'b1; st_q <= ST_PACE;
          end else begin
            st_q <= wr_q ? ST_PACE : ST_PUT;
          end
        end
        ST_PUT:  if (dev_ready_i) st_q <= ST_PACE;
        ST_HOLD: if (cycle_i >= dl_q) begin
          done_q <= 1'b1; st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase

      if (adv) begin
        retry_q <= 1'b0;
        rem_q   <= rem_q - LEN_W'(clen_q);
        moved_q <= moved_q + LEN_W'(clen_q);
        if (off_sum == (PG_W+1)'(PAGE_BYTES)) begin
          off_q <= '0;
          idx_q <= idx_q + 1'b1;
        end else begin
          off_q <= off_sum[PG_W-1:0];
        end
      end
    end
  end

  assign start_reject_o  = rej_q;
  assign busy_o          = (st_q != ST_IDLE);
  assign done_o          = done_q;
  assign err_o           = err_q;
  assign moved_o         = moved_q;
  assign pg_idx_o        = idx_q;
  assign mem_req_valid_o = (st_q == ST_REQ);
  assign mem_req_write_o = wr_q;
  assign mem_req_addr_o  = pg_addr_i + ADDR_W'(off_q);
  assign mem_req_len_o   = clen_q;
  assign dev_valid_o     = (st_q == ST_FETCH) || (st_q == ST_PUT);
  assign dev_to_mem_o    = wr_q;
  assign dev_len_o       = clen_q;
endmodule

// File: rtl/sg_dma_chan_chk.sv
module sg_dma_chan_chk #(
  parameter int LEN_W   = 16,
  parameter int TIME_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int PG_W    = 12,
  parameter int LINE_SH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [TIME_W-1:0] cycle_i,
  input logic              start_valid_i,
  input logic [LEN_W-1:0]  start_len_i,
  input logic              start_reject_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic [LINE_SH:0]  mem_req_len_o,
  input logic              mem_rsp_valid_i,
  input logic [TIME_W-1:0] dl_i,
  input logic [PG_W-1:0]   off_i
);
  logic outst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= 1'b0;
    else if (mem_req_valid_o && mem_req_ready_i) outst_q <= 1'b1;
    else if (mem_rsp_valid_i) outst_q <= 1'b0;
  end

  assert_reject_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_valid_i && (start_len_i == '0) && !busy_o) |=> (start_reject_o && !busy_o));

  assert_reject_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_valid_i && busy_o) |=> start_reject_o);

  assert_chunk_in_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> ((mem_req_len_o != '0) &&
      (int'(off_i[LINE_SH-1:0]) + int'(mem_req_len_o) <= (1 << LINE_SH))));

  assert_one_outstanding_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !outst_q);

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_len_o)));

  assert_done_at_deadline_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> ($past(cycle_i) >= dl_i));

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind sg_dma_chan sg_dma_chan_chk #(
  .LEN_W(LEN_W), .TIME_W(TIME_W), .ADDR_W(ADDR_W), .PG_W(PG_W), .LINE_SH(LINE_SH)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cycle_i         (cycle_i),
  .start_valid_i   (start_valid_i),
  .start_len_i     (start_len_i),
  .start_reject_o  (start_reject_o),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .err_o           (err_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_len_o   (mem_req_len_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .dl_i            (dl_q),
  .off_i           (off_q)
);

// File: tb/sg_dma_chan_tb.sv
`timescale 1ns/1ps
module sg_dma_chan_tb;
  localparam int LINE = 256;
  localparam int PAGE = 4096;

  typedef struct packed {
    logic [15:0]        len;
    logic [15:0]        off;
    logic               wr;
    logic signed [31:0] rdl;
    logic [7:0]         nak;
    logic [7:0]         err;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{16'd256, 16'd0,    1'b0, 32'sd1024, 8'hFF, 8'hFF},
    '{16'd300, 16'd4000, 1'b1, 32'sd600,  8'hFF, 8'hFF},
    '{16'd700, 16'd100,  1'b0, 32'sd350,  8'hFF, 8'hFF},
    '{16'd512, 16'd0,    1'b1, 32'sd400,  8'd1,  8'hFF},
    '{16'd200, 16'd50,   1'b0, 32'sd300,  8'd0,  8'hFF},
    '{16'd600, 16'd0,    1'b0, 32'sd2000, 8'hFF, 8'd1},
    '{16'd100, 16'd10,   1'b1, -32'sd50,  8'hFF, 8'hFF},
    '{16'd2,   16'd4095, 1'b0, 32'sd20,   8'hFF, 8'hFF}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cnt = '0;
  logic        start_valid = 0, start_wr = 0;
  logic [15:0] start_len = '0;
  logic [11:0] start_off = '0;
  logic [31:0] start_dl = '0;
  logic        rej, busy, done, err;
  logic [15:0] moved;
  logic [7:0]  pg_idx;
  logic [31:0] pg_addr;
  logic        rq_v, rq_w;
  logic [31:0] rq_a;
  logic [8:0]  rq_l, dv_l;
  logic        rs_v = 0;
  logic [1:0]  rs_s = 2'b00;
  logic        dv_v, dv_dir;

  int total = 0, bad = 0;
  int nreq, ndev, nak_idx, err_idx;
  bit pending, done_seen, done_err;
  longint req_a [32], req_l [32], req_c [32];
  longint done_c;

  always #2.5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1;

  function automatic logic [31:0] page_base(int i);
    return 32'h8000_0000 + 32'(i) * 32'h0001_3000;
  endfunction
  assign pg_addr = page_base(int'(pg_idx));

  sg_dma_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cycle_i(cnt),
    .start_valid_i(start_valid), .start_len_i(start_len), .start_off_i(start_off),
    .start_wr_i(start_wr), .start_deadline_i(start_dl),
    .start_reject_o(rej), .busy_o(busy), .done_o(done), .err_o(err), .moved_o(moved),
    .pg_idx_o(pg_idx), .pg_addr_i(pg_addr),
    .mem_req_valid_o(rq_v), .mem_req_ready_i(1'b1), .mem_req_write_o(rq_w),
    .mem_req_addr_o(rq_a), .mem_req_len_o(rq_l),
    .mem_rsp_valid_i(rs_v), .mem_rsp_status_i(rs_s),
    .dev_valid_o(dv_v), .dev_ready_i(1'b1), .dev_to_mem_o(dv_dir), .dev_len_o(dv_l)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  // memory and device responder, logs requests
  initial begin
    forever begin
      @(negedge clk);
      rs_v = 1'b0;
      if (pending) begin
        rs_v = 1'b1;
        rs_s = (nreq - 1 == nak_idx) ? 2'b01 : (nreq - 1 == err_idx) ? 2'b10 : 2'b00;
        pending = 0;
      end
      if (rq_v) begin
        if (nreq < 32) begin
          req_a[nreq] = rq_a; req_l[nreq] = rq_l; req_c[nreq] = cnt;
        end
        nreq++;
        pending = 1;
      end
      if (dv_v) ndev++;
      if (done && !done_seen) begin
        done_seen = 1; done_c = cnt; done_err = err;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic clear_logs(int nk, int er);
    nreq = 0; ndev = 0; pending = 0; done_seen = 0; done_err = 0;
    nak_idx = nk; err_idx = er;
  endtask

  task automatic run_vec(input vec_t v, input bit busy_poke);
    longint s, dl, ivl, off, rem, idx, cl, mv, nexp, dexp, lastk;
    bit retry, aborted;
    longint e_a [32], e_l [32], e_r [32];
    int nk, er;
    nk = (v.nak == 8'hFF) ? -1 : int'(v.nak);
    er = (v.err == 8'hFF) ? -1 : int'(v.err);
    clear_logs(nk, er);
    @(negedge clk);
    s = cnt;
    dl = s + longint'(v.rdl);
    start_valid = 1; start_len = v.len; start_off = v.off[11:0]; start_wr = v.wr;
    start_dl = 32'(dl);
    @(negedge clk);
    start_valid = 0;
    chk(busy && !rej && !err, "R2/R9 accept clears err", {busy, rej, err}, 3'b100);
    if (busy_poke) begin
      repeat (3) @(negedge clk);
      start_valid = 1; start_len = 16'd999;
      @(negedge clk);
      start_valid = 0;
      chk(rej == 1'b1 && busy, "R2 busy reject", rej, 1);
    end
    while (!done_seen) @(negedge clk);

    // reference chunk model
    if (dl < s) dl = s;
    ivl = ((dl - s) * LINE) / v.len;
    off = v.off; rem = v.len; idx = 0; mv = 0; nexp = 0; dexp = 0;
    retry = 0; aborted = 0;
    while (rem > 0 && nexp < 32 && !aborted) begin
      if (off % LINE != 0) cl = LINE - off % LINE; else cl = LINE;
      if (cl > rem) cl = rem;
      e_a[nexp] = page_base(int'(idx)) + off; e_l[nexp] = cl; e_r[nexp] = retry;
      if (v.wr && !retry) dexp++;
      if (nexp == nk) begin
        retry = 1;
      end else if (nexp == er) begin
        aborted = 1;
      end else begin
        if (!v.wr) dexp++;
        off += cl; rem -= cl; mv += cl; retry = 0;
        if (off == PAGE) begin off = 0; idx++; end
      end
      nexp++;
    end

    chk(nreq == nexp, "R8 request count", nreq, nexp);
    for (int k = 0; k < nexp && k < nreq; k++) begin
      chk(req_a[k] == e_a[k], "R6 request address", req_a[k], e_a[k]);
      chk(req_l[k] == e_l[k], "R5 request length", req_l[k], e_l[k]);
      if (k >= 1 && ivl >= 64) begin
        lastk = s + k * ivl + ((v.wr && !e_r[k]) ? 2 : 1);
        chk(req_c[k] == lastk, "R3 paced issue", req_c[k], lastk);
      end
    end
    chk(ndev == dexp, "R7 device handshakes", ndev, dexp);
    chk(moved == 16'(mv), "R12 moved bytes", moved, mv);
    chk(done_err == aborted, "R9 done status", done_err, aborted);
    chk(!busy, "R10 idle after done", busy, 0);
    if (aborted) begin
      chk(done_c < dl, "R9 abort ends early", done_c, dl);
      repeat (4) @(negedge clk);
      chk(err == 1'b1, "R9 err sticky", err, 1);
    end else if (v.rdl < 0) begin
      chk(done_c <= s + 80, "R4 clamped deadline", done_c, s + 80);
    end else if (dl > s + (nexp - 1) * ivl + 80) begin
      chk(done_c == dl + 1, "R10 done at deadline", done_c, dl + 1);
    end else begin
      chk(done_c >= dl + 1, "R10 done not early", done_c, dl + 1);
    end
  endtask

  initial begin
    clear_logs(-1, -1);
    repeat (3) @(negedge clk);
    chk({busy, done, err, rej, rq_v, dv_v} == 6'b0, "R1 reset state",
        {busy, done, err, rej, rq_v, dv_v}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({busy, done, err, rej, rq_v, dv_v} == 6'b0, "R1 idle after reset",
        {busy, done, err, rej, rq_v, dv_v}, 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

    // zero-length start rejected, nothing starts
    @(negedge clk);
    start_valid = 1; start_len = 16'd0; start_dl = cnt + 100;
    @(negedge clk);
    start_valid = 0;
    chk(rej == 1'b1, "R2 zero length reject", rej, 1);
    chk(busy == 1'b0, "R2 zero length ignored", busy, 0);
    @(negedge clk);
    chk(rej == 1'b0, "R2 reject one cycle", rej, 0);

    // start while busy is rejected and does not disturb the transfer
    run_vec('{16'd256, 16'd0, 1'b0, 32'sd300, 8'hFF, 8'hFF}, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule